// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps it refreshed. After reset it waits a pause of fixed length with every strobe inactive. It then runs a burst of refresh cycles in which CAS falls before RAS. After that it issues one such refresh per refresh interval. The DRAM counts its refresh rows internally, so the block drives no address. The block drives the RAS strobe, both byte CAS strobes and the write strobe, and holds write high at all times.

The strobe pins are shared with an access controller through a request/grant handshake. The block raises `ref_req` and waits for `ref_gnt`. While it owns the pins it raises `own_bus`. It drops both once RAS precharge is complete at the end of a cycle. Refreshes that the access controller postpones are counted. When more than a set number are outstanding, `overdue` tells the controller to yield. `init_done` tells it when normal accesses may begin.

All timings are given in nanoseconds and converted to whole clock cycles. Minimum times are rounded up. The refresh interval is rounded down, so refresh is never late.

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset and straight after it, `ras_n`, `cas_lo_n` and `cas_hi_n` are high, and `ref_req`, `own_bus`, `init_done` and `overdue` are low. Reset is asynchronous and releases the strobes at once, even in the middle of a refresh cycle.
- R2: `ref_req` first goes high exactly PAUSE_CYC clock edges after reset is released, and not before.
- R3: `init_done` rises at the end of the INIT_REFS-th refresh cycle after reset (8 by default), and no other RAS cycle occurs before it.
- R4: A refresh cycle starts only on a clock edge at which `ref_gnt` is high while `ref_req` is high. With grant withheld, no strobe moves and `own_bus` stays low.
- R5: Both CAS strobes fall together while RAS is high. They stay low for exactly CSR_CYC cycles before RAS falls, and they remain low for as long as RAS is low.
- R6: RAS stays low for exactly RAS_CYC cycles in every refresh cycle and never longer.
- R7: Once the block owns the pins, all strobes stay high for PRE_CYC cycles before CAS falls. After RAS rises, all strobes stay high for PRE_CYC cycles before `own_bus` drops.
- R8: `we_n` is high whenever RAS falls, and at all other times.
- R9: After `init_done`, a refresh becomes due every INTERVAL_CYC cycles. With grant always given, successive RAS falls are exactly INTERVAL_CYC cycles apart.
- R10: Each due refresh that has not yet been served is counted as outstanding. `overdue` is high exactly when that count exceeds POSTPONE_MAX, and it clears once the backlog has been served.
- R11: Every interval tick yields exactly one refresh cycle. This also holds when a tick and the end of a refresh cycle fall on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_gnt | input | 1 | Grant of the strobe pins from the access controller |
| ref_req | output | 1 | Request for the strobe pins |
| own_bus | output | 1 | High while the block drives the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower-byte column strobe, active low |
| cas_hi_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write strobe, held inactive high |
| init_done | output | 1 | Power-up sequence complete; normal accesses allowed |
| overdue | output | 1 | Outstanding refreshes exceed the postponement limit |

## Verification
The interval tick and the end of a refresh cycle can land on the same clock edge. The outstanding count must then stay unchanged rather than lose a refresh or gain one. This is provoked by withholding grant after initialization for a range of hold-off lengths. The backlog service then ends at different phases against the next tick. Each run is judged by counting RAS falls at a point midway between ticks, and that count must equal the number of elapsed intervals. The same runs check `overdue` against the number of intervals that passed before grant was given.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int CLK_PERIOD_PS = 20000,
  parameter int PAUSE_NS      = 100000,
  parameter int INTERVAL_NS   = 15600,
  parameter int CSR_NS        = 10,
  parameter int RAS_NS        = 60,
  parameter int PRE_NS        = 40,
  parameter int INIT_REFS     = 8,
  parameter int POSTPONE_MAX  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic own_bus,
  output logic ras_n,
  output logic cas_lo_n,
  output logic cas_hi_n,
  output logic we_n,
  output logic init_done,
  output logic overdue
);

  localparam int PAUSE_CYC    = (PAUSE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int INTERVAL_CYC = (INTERVAL_NS * 1000) / CLK_PERIOD_PS;
  localparam int CSR_RAW      = (CSR_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RAS_RAW      = (RAS_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int PRE_RAW      = (PRE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int CSR_CYC      = CSR_RAW < 1 ? 1 : CSR_RAW;
  localparam int RAS_CYC      = RAS_RAW < 1 ? 1 : RAS_RAW;
  localparam int PRE_CYC      = PRE_RAW < 1 ? 1 : PRE_RAW;
  localparam int DUR_MAX      = RAS_CYC > PRE_CYC ? (RAS_CYC > CSR_CYC ? RAS_CYC : CSR_CYC)
                                                  : (PRE_CYC > CSR_CYC ? PRE_CYC : CSR_CYC);
  localparam int CNT_W        = $clog2(DUR_MAX + 1);
  localparam int PAUSE_W      = $clog2(PAUSE_CYC + 1);
  localparam int TMR_W        = $clog2(INTERVAL_CYC + 1);
  localparam int INIT_W       = $clog2(INIT_REFS + 1);
  localparam int PEND_MAX     = 2 * POSTPONE_MAX + 2;
  localparam int PEND_W       = $clog2(PEND_MAX + 1);
  localparam int RL_W         = $clog2(RAS_CYC + 2);

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_SETUP, S_ACT, S_REC} st_t;
  typedef enum logic [1:0] {P_PAUSE, P_BURST, P_RUN} ph_t;

  st_t               state;
  ph_t               phase;
  logic [CNT_W-1:0]  cnt;
  logic [PAUSE_W-1:0] pcnt;
  logic [TMR_W-1:0]  tcnt;
  logic [INIT_W-1:0] icnt;
  logic [PEND_W-1:0] pending;
  logic              done, want, tick, run_done;

  assign done     = (state == S_REC) && (cnt == '0);
  assign want     = (phase == P_BURST) || ((phase == P_RUN) && (pending != '0));
  assign tick     = (phase == P_RUN) && (tcnt == TMR_W'(INTERVAL_CYC - 1));
  assign run_done = done && (phase == P_RUN);

  assign own_bus  = (state != S_IDLE);
  assign ref_req  = want || own_bus;
  assign ras_n    = (state != S_ACT);
  assign cas_lo_n = !((state == S_SETUP) || (state == S_ACT));
  assign cas_hi_n = !((state == S_SETUP) || (state == S_ACT));
  assign we_n     = 1'b1;
  assign overdue  = (pending > PEND_W'(POSTPONE_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (want && ref_gnt) begin
            state <= S_PREP;
            cnt   <= CNT_W'(PRE_CYC - 1);
          end
        S_PREP:
          if (cnt == '0) begin
            state <= S_SETUP;
            cnt   <= CNT_W'(CSR_CYC - 1);
          end else cnt <= cnt - 1'b1;
        S_SETUP:
          if (cnt == '0) begin
            state <= S_ACT;
            cnt   <= CNT_W'(RAS_CYC - 1);
          end else cnt <= cnt - 1'b1;
        S_ACT:
          if (cnt == '0) begin
            state <= S_REC;
            cnt   <= CNT_W'(PRE_CYC - 1);
          end else cnt <= cnt - 1'b1;
        S_REC:
          if (cnt == '0) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= P_PAUSE;
      pcnt      <= '0;
      icnt      <= '0;
      init_done <= 1'b0;
    end else begin
      case (phase)
        P_PAUSE:
          if (pcnt == PAUSE_W'(PAUSE_CYC - 1)) phase <= P_BURST;
          else pcnt <= pcnt + 1'b1;
        P_BURST:
          if (done) begin
            if (icnt == INIT_W'(INIT_REFS - 1)) begin
              phase     <= P_RUN;
              init_done <= 1'b1;
            end else icnt <= icnt + 1'b1;
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt    <= '0;
      pending <= '0;
    end else begin
      if (phase != P_RUN || tick) tcnt <= '0;
      else tcnt <= tcnt + 1'b1;
      case ({tick, run_done})
        2'b10: if (pending != PEND_W'(PEND_MAX)) pending <= pending + 1'b1;
        2'b01: pending <= pending - 1'b1;
        default: ;
      endcase
    end
  end

  logic [RL_W-1:0] ras_low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ras_low_len <= '0;
    else if (!ras_n) begin
      if (ras_low_len != RL_W'(RAS_CYC + 1)) ras_low_len <= ras_low_len + 1'b1;
    end else ras_low_len <= '0;
  end

  // R1
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !own_bus |-> (ras_n && cas_lo_n && cas_hi_n));

  // R4
  start_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_bus) |-> $past(ref_gnt) && $past(ref_req));

  // R5
  ras_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_lo_n && !cas_hi_n && $past(!cas_lo_n) && $past(!cas_hi_n)));

  // R6
  ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (ras_low_len < RL_W'(RAS_CYC)));

  // R7
  cas_after_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_lo_n) |-> ($past(own_bus) && $past(ras_n)));

  // R10
  overdue_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overdue |-> (ref_req && init_done));

endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
  localparam int PAUSE = 40, INTV = 60, CSR = 2, RASC = 4, PRE = 2, NINIT = 8, PMAX = 2;
  localparam int NV = 6;
  localparam int HOLD [NV] = '{5, 70, 130, 175, 200, 250};

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b1;
  logic req, own, ras_n, clo_n, chi_n, we_n, idone, ovd;
  int nchk = 0, nfail = 0, cyc = 0, ras_falls = 0;
  int cas_run = 0, ras_run = 0, hi_run = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_own = 1'b0;
  bit finished = 0;

  always #10 clk = ~clk;

  dram_refresh_seq #(.CLK_PERIOD_PS(20000), .PAUSE_NS(800), .INTERVAL_NS(1200),
    .CSR_NS(30), .RAS_NS(80), .PRE_NS(40), .INIT_REFS(NINIT), .POSTPONE_MAX(PMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req), .own_bus(own),
    .ras_n(ras_n), .cas_lo_n(clo_n), .cas_hi_n(chi_n), .we_n(we_n),
    .init_done(idone), .overdue(ovd));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_ras = 1'b1; p_cas = 1'b1; p_own = 1'b0;
      cas_run = 0; ras_run = 0; hi_run = 0; ras_falls = 0;
    end else begin
      if (p_ras && !ras_n) begin
        ras_falls++;
        chk(cas_run == CSR, "R5 cas lead before ras", cas_run, CSR);
        chk(!clo_n && !chi_n, "R5 both cas low at ras fall", {clo_n, chi_n}, 0);
        chk(we_n, "R8 we high at ras fall", we_n, 1);
      end
      if (!ras_n && (clo_n || chi_n)) chk(0, "R5 cas low while ras low", {clo_n, chi_n}, 0);
      if (!p_ras && ras_n) chk(ras_run == RASC, "R6 ras low width", ras_run, RASC);
      if (p_cas && !clo_n && ras_n) chk(hi_run == PRE, "R7 precharge before cas", hi_run, PRE);
      if (p_own && !own) chk(hi_run == PRE, "R7 precharge before release", hi_run, PRE);
      ras_run = !ras_n ? ras_run + 1 : 0;
      cas_run = (!clo_n && ras_n) ? cas_run + 1 : 0;
      hi_run  = (own && ras_n && clo_n && chi_n) ? hi_run + 1 : 0;
      p_ras = ras_n; p_cas = clo_n; p_own = own;
    end
  end

  task automatic check_reset_state(input string tag);
    chk(ras_n && clo_n && chi_n, {tag, " strobes high"}, {ras_n, clo_n, chi_n}, 7);
    chk(!req && !own && !idone && !ovd, {tag, " flags low"}, {req, own, idone, ovd}, 0);
  endtask

  task automatic start_and_init();
    int n;
    rst_n = 1'b0; gnt = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("R1 in reset");
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!req && n < 1000);
    chk(n == PAUSE, "R2 pause before first request", n, PAUSE);
    n = 0;
    while (!idone && n < 2000) begin @(negedge clk); n++; end
    chk(ras_falls == NINIT, "R3 init refresh count", ras_falls, NINIT);
  endtask

  initial begin
    for (int v = 0; v < NV; v++) begin
      int d, m, base, pend;
      start_and_init();
      gnt = 1'b0;
      base = ras_falls;
      d = HOLD[v];
      pend = d / INTV;
      m = pend + 3;
      repeat (d) @(negedge clk);
      chk(ras_falls == base && !own, "R4 no cycle without grant", ras_falls - base, 0);
      chk(ovd == (pend > PMAX), "R10 overdue vs postponed count", ovd, pend > PMAX);
      chk(req == (pend > 0), "R9 request after interval", req, pend > 0);
      gnt = 1'b1;
      repeat (m * INTV + INTV / 2 - d) @(negedge clk);
      chk(ras_falls - base == m, "R11 one refresh per tick", ras_falls - base, m);
      chk(!ovd && !req, "R10 overdue cleared after catch-up", {ovd, req}, 0);
    end

    begin
      int f0, t1, n;
      start_and_init();
      f0 = ras_falls; t1 = 0; n = 0;
      while (ras_falls < f0 + 1 && n < 1000) begin @(negedge clk); n++; end
      t1 = cyc;
      while (ras_falls < f0 + 2 && n < 2000) begin @(negedge clk); n++; end
      chk(cyc - t1 == INTV, "R9 refresh spacing", cyc - t1, INTV);
    end

    begin
      int n;
      start_and_init();
      n = 0;
      while (ras_n && n < 1000) begin @(negedge clk); n++; end
      rst_n = 1'b0;
      #1;
      check_reset_state("R1 reset mid-cycle");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!req && ras_n, "R1 idle after reset release", {req, ras_n}, 1);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule